// File: doc/BRIEF.md
# Zero-Bus-Turnaround Flow-Through Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous SRAM that lets reads and writes follow one another on every clock with no idle cycle on the data bus. All control is sampled on the rising clock edge. The data phase of each access happens one clock after its command. Read data flows from the array to the output without an output register. Write data is taken from the data input at the end of the data cycle, and each 9-bit lane has its own enable.

A command cycle can do one of three things. It can load a new address and direction. It can deselect the device, which ends any burst in progress. It can advance an internal 2-bit burst counter, which walks the four words of an aligned group in either linear or interleaved order. A clock-enable input held high, or the sleep input, makes an edge act as if it never happened. The bidirectional bus is split into a data input, a data output and an output-valid flag, and the valid flag is also gated asynchronously by an output-enable input.

Top module: `zbt_ft_sram`

## Requirements
- R1: The device is selected only when `cs1_n`=0, `cs2_n`=0 and `cs_hi`=1. A load attempted with any one of these inactive produces no data phase.
- R2: An active edge with `adv_ld`=0 and the device selected loads `addr` and `rd_wr_n` (1 = read, 0 = write). The data phase follows in the next cycle.
- R3: In the data cycle of a read, `dout` equals the addressed word and `dout_en`=1 when `oe_n`=0. Reads and writes may be issued on consecutive cycles, and a read issued right after a write to the same word returns the new data.
- R4: A write updates lane i (`din[9i+8:9i]`) only when `byte_we_n[i]`=0 on the command cycle, taking `din` at the edge that ends the data cycle. Other lanes keep their contents, and `dout_en` stays 0 during a write data cycle.
- R5: `byte_we_n` has no effect on reads. Stored words are unchanged after a read made with all lane enables low.
- R6: An active edge with `adv_ld`=0 and the device not selected starts a deselect. `dout_en` is 0 in the next cycle, and later `adv_ld`=1 edges produce no data phase until a new load.
- R7: An active edge with `adv_ld`=1 during a burst ignores `addr`, keeps the loaded direction and accesses the next burst address. This applies to burst writes too.
- R8: With `burst_ilv`=0, beat k of a burst uses low address bits (start + k) mod 4. The upper bits are kept.
- R9: With `burst_ilv`=1, beat k uses low address bits start XOR k.
- R10: After four beats the burst counter wraps, so the fifth beat accesses the starting word again.
- R11: An edge with `clk_en_n`=1 changes no state or output. Commands present at that edge are ignored, and pending write data is taken at the next active edge.
- R12: An edge with `sleep`=1 behaves as a stalled edge, and the array keeps its contents.
- R13: `oe_n`=1 forces `dout_en` to 0 without waiting for a clock edge.
- R14: After reset `dout_en`=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en_n | input | 1 | Active-low clock enable |
| sleep | input | 1 | Sleep request, freezes the device |
| addr | input | ADDR_W | Word address for load cycles |
| adv_ld | input | 1 | 0 = load or deselect, 1 = advance burst |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| cs1_n | input | 1 | Active-low chip select |
| cs2_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| byte_we_n | input | BYTES | Active-low lane write enables |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | BYTES*BYTE_W | Write data |
| dout | output | BYTES*BYTE_W | Read data (zero when not driven) |
| dout_en | output | 1 | Read data valid / bus driven |

## Verification
A wrong pipeline register would show on the port one cycle after the command that set it. The symptoms would be a read whose `dout_en` is missing, a write cycle that drives the bus, or data taken from the wrong word. A burst counter that steps wrongly or fails to wrap would return the wrong word on the very beat that goes astray, so every burst beat is compared in both orders from each starting offset. Errors in stall and lane handling stay hidden in the array until that word is read back. For that reason every write is followed by a read of the same word, and the lane enables are swept over all sixteen patterns.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_ord_e;

   typedef enum logic {
      DIR_WRITE = 1'b0,
      DIR_READ  = 1'b1
   } dir_e;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
   parameter int BURST_W = 2
) (
   input  logic [BURST_W-1:0] start_ofs,
   input  logic [BURST_W-1:0] beat,
   input  zbt_pkg::burst_ord_e order,
   output logic [BURST_W-1:0] ofs
);
   logic [BURST_W-1:0] lin_ofs;
   logic [BURST_W-1:0] ilv_ofs;

   // linear order wraps naturally through the counter width
   assign lin_ofs = start_ofs + beat;

   for (genvar b = 0; b < BURST_W; b++) begin : g_ilv_bit
      assign ilv_ofs[b] = start_ofs[b] ^ beat[b];
   end

   always_comb begin
      if (order == zbt_pkg::ORD_INTERLEAVE) ofs = ilv_ofs;
      else                                  ofs = lin_ofs;
   end
endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl #(
   parameter int ADDR_W  = 6,
   parameter int BYTES   = 4,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] addr,
   input  logic              adv_ld,
   input  logic              rd_wr_n,
   input  logic              sel,
   input  logic [BYTES-1:0]  byte_we_n,
   input  logic              burst_ilv,
   output logic              dp_valid,
   output logic              dp_rd,
   output logic [ADDR_W-1:0] dp_addr,
   output logic [BYTES-1:0]  dp_be_n,
   output logic              burst_live
);
   localparam int HI_W = ADDR_W - BURST_W;

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] cnt_nxt;
   logic [BURST_W-1:0] seq_ofs;
   logic [ADDR_W-1:0]  adv_addr;
   logic               live_q;
   logic               rd_q;
   zbt_pkg::burst_ord_e order;

   assign order    = zbt_pkg::burst_ord_e'(burst_ilv);
   assign cnt_nxt  = cnt_q + BURST_W'(1);
   assign adv_addr = {base_q[ADDR_W-1 -: HI_W], seq_ofs};
   assign burst_live = live_q;

   zbt_burst_seq #(.BURST_W(BURST_W)) i_seq (
      .start_ofs (base_q[BURST_W-1:0]),
      .beat      (cnt_nxt),
      .order     (order),
      .ofs       (seq_ofs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         cnt_q    <= '0;
         live_q   <= 1'b0;
         rd_q     <= zbt_pkg::DIR_READ;
         dp_valid <= 1'b0;
         dp_rd    <= zbt_pkg::DIR_READ;
         dp_addr  <= '0;
         dp_be_n  <= '1;
      end else if (go) begin
         dp_be_n <= byte_we_n;
         if (!adv_ld) begin
            if (sel) begin
               base_q   <= addr;
               cnt_q    <= '0;
               live_q   <= 1'b1;
               rd_q     <= rd_wr_n;
               dp_valid <= 1'b1;
               dp_rd    <= rd_wr_n;
               dp_addr  <= addr;
            end else begin
               live_q   <= 1'b0;
               dp_valid <= 1'b0;
            end
         end else if (live_q) begin
            cnt_q    <= cnt_nxt;
            dp_valid <= 1'b1;
            dp_rd    <= rd_q;
            dp_addr  <= adv_addr;
         end else begin
            dp_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  logic                    wr_go,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [BYTES-1:0]        be_n,
   input  logic [BYTES*BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [BYTES*BYTE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_go && !be_n[g]) mem[wr_addr] <= wdata[g*BYTE_W +: BYTE_W];
      end

      // flow-through: no register between array and read port
      assign rdata[g*BYTE_W +: BYTE_W] = mem[rd_addr];
   end
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram #(
   parameter int ADDR_W  = 6,
   parameter int BYTES   = 4,
   parameter int BYTE_W  = 9,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    sleep,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    adv_ld,
   input  logic                    rd_wr_n,
   input  logic                    cs1_n,
   input  logic                    cs2_n,
   input  logic                    cs_hi,
   input  logic [BYTES-1:0]        byte_we_n,
   input  logic                    burst_ilv,
   input  logic                    oe_n,
   input  logic [BYTES*BYTE_W-1:0] din,
   output logic [BYTES*BYTE_W-1:0] dout,
   output logic                    dout_en
);
   localparam int DATA_W = BYTES * BYTE_W;

   initial begin
      if (BURST_W < 1)       $fatal(1, "BURST_W must be at least 1");
      if (ADDR_W <= BURST_W) $fatal(1, "ADDR_W must exceed BURST_W");
      if (BYTES < 1)         $fatal(1, "BYTES must be at least 1");
      if (BYTE_W < 1)        $fatal(1, "BYTE_W must be at least 1");
   end

   logic              go;
   logic              sel;
   logic              dp_valid;
   logic              dp_rd;
   logic [ADDR_W-1:0] dp_addr;
   logic [BYTES-1:0]  dp_be_n;
   logic              burst_live;
   logic              wr_go;
   logic [DATA_W-1:0] rd_data;

   assign go    = !clk_en_n && !sleep;
   assign sel   = !cs1_n && !cs2_n && cs_hi;
   assign wr_go = go && dp_valid && (dp_rd == zbt_pkg::DIR_WRITE);

   zbt_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BURST_W(BURST_W)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .addr       (addr),
      .adv_ld     (adv_ld),
      .rd_wr_n    (rd_wr_n),
      .sel        (sel),
      .byte_we_n  (byte_we_n),
      .burst_ilv  (burst_ilv),
      .dp_valid   (dp_valid),
      .dp_rd      (dp_rd),
      .dp_addr    (dp_addr),
      .dp_be_n    (dp_be_n),
      .burst_live (burst_live)
   );

   zbt_lane_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) i_array (
      .clk     (clk),
      .wr_go   (wr_go),
      .wr_addr (dp_addr),
      .be_n    (dp_be_n),
      .wdata   (din),
      .rd_addr (dp_addr),
      .rdata   (rd_data)
   );

   assign dout_en = dp_valid && dp_rd && !oe_n;
   assign dout    = dout_en ? rd_data : '0;
endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_n,
   input logic              sleep,
   input logic              adv_ld,
   input logic              rd_wr_n,
   input logic              cs1_n,
   input logic              cs2_n,
   input logic              cs_hi,
   input logic              burst_ilv,
   input logic              oe_n,
   input logic              dout_en,
   input logic              dp_valid,
   input logic              dp_rd,
   input logic [ADDR_W-1:0] dp_addr,
   input logic              burst_live
);
   logic act;
   logic picked;
   assign act    = !clk_en_n && !sleep;
   assign picked = !cs1_n && !cs2_n && cs_hi;

   assert_oe_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_en);

   assert_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !adv_ld && !picked) |=> !dout_en);

   assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !adv_ld && picked && !rd_wr_n) |=> !dout_en);

   assert_read_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !adv_ld && picked && rd_wr_n) |=> (dout_en || oe_n));

   assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!act) |=> ($stable(dp_valid) && $stable(dp_rd) && $stable(dp_addr) && $stable(burst_live)));

   assert_linear_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act && adv_ld && burst_live && !burst_ilv) |=> (dp_addr[1:0] == $past(dp_addr[1:0]) + 2'd1));

   assert_group_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act && adv_ld && burst_live) |=> (dp_addr[ADDR_W-1:2] == $past(dp_addr[ADDR_W-1:2])));
endmodule

bind zbt_ft_sram zbt_ft_sram_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_en_n   (clk_en_n),
   .sleep      (sleep),
   .adv_ld     (adv_ld),
   .rd_wr_n    (rd_wr_n),
   .cs1_n      (cs1_n),
   .cs2_n      (cs2_n),
   .cs_hi      (cs_hi),
   .burst_ilv  (burst_ilv),
   .oe_n       (oe_n),
   .dout_en    (dout_en),
   .dp_valid   (dp_valid),
   .dp_rd      (dp_rd),
   .dp_addr    (dp_addr),
   .burst_live (burst_live)
);

// File: tb/test_zbt_ft_sram.sv
module test_zbt_ft_sram;
   localparam int AW = 6;
   localparam int NB = 4;
   localparam int BW = 9;
   localparam int DW = NB * BW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b0;
   logic          sleep = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          adv_ld = 1'b0;
   logic          rd_wr_n = 1'b1;
   logic          cs1_n = 1'b1;
   logic          cs2_n = 1'b0;
   logic          cs_hi = 1'b1;
   logic [NB-1:0] byte_we_n = '1;
   logic          burst_ilv = 1'b0;
   logic          oe_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [DW-1:0] ref_mem [DEPTH];

   always #10 clk = ~clk;

   zbt_ft_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW), .BURST_W(2)) i_zbt_ft_sram (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sleep(sleep), .addr(addr),
      .adv_ld(adv_ld), .rd_wr_n(rd_wr_n), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs_hi(cs_hi),
      .byte_we_n(byte_we_n), .burst_ilv(burst_ilv), .oe_n(oe_n), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   function automatic logic [DW-1:0] pat(input int a, input int s);
      logic [DW-1:0] v;
      v = DW'(a) * 36'd2654435 + DW'(s) * 36'd40503 + 36'h5A5A5A5A5;
      return v ^ (DW'(a) << 20);
   endfunction

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                           input logic [DW-1:0] new_w,
                                           input logic [NB-1:0] be);
      logic [DW-1:0] r;
      r = old_w;
      for (int i = 0; i < NB; i++)
         if (!be[i]) r[i*BW +: BW] = new_w[i*BW +: BW];
      return r;
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ld(input logic rd, input int a, input logic [NB-1:0] be);
      adv_ld = 1'b0; rd_wr_n = rd; cs1_n = 1'b0; cs2_n = 1'b0; cs_hi = 1'b1;
      addr = AW'(a); byte_we_n = be;
   endtask

   task automatic adv(input logic [NB-1:0] be);
      adv_ld = 1'b1; addr = ~addr; byte_we_n = be;
   endtask

   task automatic desel(input int which);
      adv_ld = 1'b0; cs1_n = 1'b0; cs2_n = 1'b0; cs_hi = 1'b1;
      if (which == 0) cs1_n = 1'b1;
      else if (which == 1) cs2_n = 1'b1;
      else cs_hi = 1'b0;
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int base;
      int exp_a;
      logic [DW-1:0] hold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R14: reset state
      chk("R14 reset dout_en", DW'(dout_en), DW'(0));
      tick();
      chk("R14 idle dout_en", DW'(dout_en), DW'(0));

      // R2/R4: fill every word, write data one cycle after each command
      for (int a = 0; a < DEPTH; a++) begin
         ld(1'b0, a, '0);
         din = (a > 0) ? pat(a - 1, 0) : '1;
         tick();
         chk("R4 write cycle quiet", DW'(dout_en), DW'(0));
         if (a > 0) ref_mem[a-1] = pat(a - 1, 0);
      end
      desel(0); din = pat(DEPTH - 1, 0); tick();
      ref_mem[DEPTH-1] = pat(DEPTH - 1, 0);

      // R3/R5: back-to-back reads with all lane enables low
      for (int a = 0; a < DEPTH; a++) begin
         ld(1'b1, a, '0); din = '1;
         tick();
         chk("R3 read valid", DW'(dout_en), DW'(1));
         chk("R3 read data", dout, ref_mem[a]);
      end
      desel(1); tick();
      chk("R6 deselect after read", DW'(dout_en), DW'(0));
      for (int a = 0; a < 4; a++) begin
         ld(1'b1, a, '0); tick();
         chk("R5 read unchanged by lane enables", dout, ref_mem[a]);
      end

      // R3: write then immediate read of the same word, then a write
      ld(1'b0, 10, '0); tick();
      ld(1'b1, 10, '1); din = pat(10, 1); tick();
      ref_mem[10] = pat(10, 1);
      chk("R3 read after write", dout, ref_mem[10]);
      ld(1'b0, 11, '0); din = '0; tick();
      chk("R3 read to write turnaround", DW'(dout_en), DW'(0));
      desel(2); din = pat(11, 1); tick();
      ref_mem[11] = pat(11, 1);
      ld(1'b1, 11, '1); tick();
      chk("R3 turnaround write data", dout, ref_mem[11]);

      // R4: sweep all lane enable patterns
      for (int m = 0; m < 16; m++) begin
         ld(1'b0, 16 + m, NB'(m)); tick();
         desel(0); din = pat(16 + m, 2); tick();
         ref_mem[16+m] = merge(ref_mem[16+m], pat(16 + m, 2), NB'(m));
      end
      for (int m = 0; m < 16; m++) begin
         ld(1'b1, 16 + m, '1); tick();
         chk("R4 lane merge", dout, ref_mem[16+m]);
      end

      // R8/R9/R10: read bursts, both orders, every start offset, with wrap
      for (int ord = 0; ord < 2; ord++) begin
         for (int off = 0; off < 4; off++) begin
            burst_ilv = ord[0];
            base = 40 + off;
            ld(1'b1, base, '1); tick();
            chk("R2 burst load", dout, ref_mem[base]);
            for (int k = 1; k <= 4; k++) begin
               adv('0); tick();
               exp_a = 40 + ((ord == 1) ? (off ^ (k % 4)) : ((off + k) % 4));
               if (k == 4) chk("R10 burst wrap", dout, ref_mem[exp_a]);
               else if (ord == 1) chk("R9 interleaved beat", dout, ref_mem[exp_a]);
               else chk("R8 linear beat", dout, ref_mem[exp_a]);
            end
            desel(0); tick();
         end
      end
      burst_ilv = 1'b0;

      // R7: linear burst write starting at offset 2, address inputs ignored
      ld(1'b0, 50, '0); tick();
      for (int k = 0; k < 4; k++) begin
         if (k < 3) adv('0); else desel(1);
         din = pat(48 + ((2 + k) % 4), 3); tick();
         ref_mem[48 + ((2 + k) % 4)] = pat(48 + ((2 + k) % 4), 3);
         chk("R7 burst write quiet", DW'(dout_en), DW'(0));
      end
      for (int a = 48; a < 52; a++) begin
         ld(1'b1, a, '1); tick();
         chk("R7 burst write data", dout, ref_mem[a]);
      end

      // R1: a load with any one select inactive gives no data phase
      for (int w = 0; w < 3; w++) begin
         ld(1'b1, 5, '1); desel(w); rd_wr_n = 1'b1; tick();
         chk("R1 unselected load", DW'(dout_en), DW'(0));
      end

      // R6: deselect ends a burst
      ld(1'b1, 40, '1); tick();
      desel(1); tick();
      chk("R6 deselect", DW'(dout_en), DW'(0));
      adv('1); tick();
      chk("R6 no advance after deselect", DW'(dout_en), DW'(0));

      // R11: clock enable stall during a read burst ignores a new load
      ld(1'b1, 40, '1); tick();
      clk_en_n = 1'b1; ld(1'b1, 60, '1);
      for (int s = 0; s < 2; s++) begin
         tick();
         chk("R11 stall holds valid", DW'(dout_en), DW'(1));
         chk("R11 stall holds data", dout, ref_mem[40]);
      end
      clk_en_n = 1'b0; adv('1); tick();
      chk("R11 burst resumes", dout, ref_mem[41]);
      // R11: stall inside a write data cycle
      ld(1'b0, 52, '0); tick();
      clk_en_n = 1'b1; din = '1; desel(0); tick();
      chk("R11 stalled write quiet", DW'(dout_en), DW'(0));
      clk_en_n = 1'b0; din = pat(52, 4); tick();
      ref_mem[52] = pat(52, 4);
      ld(1'b1, 52, '1); tick();
      chk("R11 write after stall", dout, ref_mem[52]);

      // R12: sleep acts as a stall and keeps the array
      ld(1'b1, 44, '1); tick();
      sleep = 1'b1; ld(1'b0, 44, '0); din = '0;
      repeat (3) tick();
      chk("R12 sleep holds data", dout, ref_mem[44]);
      sleep = 1'b0; adv('1); tick();
      chk("R12 burst after sleep", dout, ref_mem[45]);
      ld(1'b1, 44, '1); tick();
      chk("R12 contents kept", dout, ref_mem[44]);

      // R13: asynchronous output enable
      oe_n = 1'b1; #1;
      chk("R13 oe high", DW'(dout_en), DW'(0));
      oe_n = 1'b0; #1;
      chk("R13 oe low", DW'(dout_en), DW'(1));
      chk("R13 oe low data", dout, ref_mem[44]);

      desel(0); tick();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule